// File: doc/BRIEF.md
# Power-Good Startup Sequencer

This block brings a clock generator out of power-up in a fixed order. Once it leaves reset it waits for the active-low power-good input to assert. It then waits a programmed number of reference-clock cycles and captures the hardware strap pins, such as the frequency selects, into registers. A second programmed wait gives the synthesizers time to settle, and at the end of it the clock outputs are enabled. From the first observed power-good assertion onward, the power-good pin has no further effect until the next reset.

A power-down request that arrives within a short window after power-good makes the block park in a power-down phase instead of enabling outputs. It leaves that phase when the request is withdrawn. In normal operation the power-down request only gates the output enable. The power-good and power-down pins are asynchronous and pass through a synchronizer of configurable depth. The straps are treated as static pins and are not synchronized.

Top module: `startup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `phase` to 0 (off), `straps_q` to 0, `straps_valid` to 0 and `outputs_en` to 0. The first edge after `rst` falls moves `phase` to 1 (waiting for power-good).
- R2: `pwrgd_n` and `pd` each pass through a flop chain `SYNC_STAGES` deep. While `phase` is 1 and the synchronized power-good is inactive, `phase` stays 1. A low level on `pwrgd_n` that is set up before edge 1 moves `phase` to 2 (pre-sample delay) at edge `SYNC_STAGES`+1.
- R3: `SAMPLE_DLY` edges after the edge that entered phase 2, `strap_in` is captured into `straps_q`. At that same edge `straps_valid` rises and `phase` becomes 3 (settle).
- R4: Once captured, `straps_q` and `straps_valid` keep their values until reset, whatever `strap_in` does afterwards.
- R5: `SETTLE_DLY` edges after the edge that entered phase 3, `phase` leaves phase 3. `outputs_en` is 0 in every phase other than 4.
- R6: If the synchronized `pd` is high at any of the `PD_WIN` edges that follow the edge which entered phase 2, the exit from phase 3 goes to phase 5 (power-down) with `outputs_en` at 0. Otherwise the exit goes to phase 4 (run).
- R7: In phase 5, the first edge at which the synchronized `pd` is low moves `phase` to 4.
- R8: In phase 4, `outputs_en` equals the inverse of the synchronized `pd`. A `pd` that is first seen after the window never leads to phase 5.
- R9: From phase 2 onward, `pwrgd_n` has no effect. Toggling it changes neither `phase`, `straps_q` nor `outputs_en`, and phase 4 is kept until reset.
- R10: `phase` only advances along 0, 1, 2, 3, then 4 or 5, and from 5 to 4. It never moves backward except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| pwrgd_n | input | 1 | Power-good, active low, asynchronous |
| pd | input | 1 | Power-down request, active high, asynchronous |
| strap_in | input | STRAP_W | Static hardware strap pins |
| phase | output | 3 | Current sequencer phase: 0 off, 1 wait power-good, 2 pre-sample, 3 settle, 4 run, 5 power-down |
| straps_q | output | STRAP_W | Captured strap values |
| straps_valid | output | 1 | High once the straps have been captured |
| outputs_en | output | 1 | Clock output enable |

## Verification
Every internal fault surfaces on `phase` and `outputs_en` within one edge of the cycle in which it occurs. The bench pins each phase change to the exact edge count after the power-good drive. A delay counter that is off by one, or a synchronizer of the wrong depth, therefore shows up as a wrong phase one cycle early or late. A wrongly sized power-down window shows up at the end of settling as run instead of power-down, or the reverse, when probed with requests on the last edge inside the window and the first edge outside it. A strap register that is captured at the wrong time or recaptured later shows up as a mismatch on `straps_q`, because the bench presents the correct strap value for exactly one edge and changes it right after.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_WAIT_PG = 3'd1,
        PH_PRE     = 3'd2,
        PH_SETTLE  = 3'd3,
        PH_RUN     = 3'd4,
        PH_PWRDN   = 3'd5
    } phase_e;

    // synchronized control pins, both active high inside the block
    typedef struct packed {
        logic pg;
        logic pd;
    } ctl_s;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // bits needed to hold values 0 .. m-1
    function automatic int unsigned cnt_width(int unsigned m);
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/sseq_sync.sv
module sseq_sync #(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sseq_timer.sv
module sseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // an idle timer must rest at zero, never wrap
    p_hold_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/sseq_strap_latch.sv
module sseq_strap_latch #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            valid <= 1'b0;
        end else if (capture && !valid) begin
            q     <= d;
            valid <= 1'b1;
        end
    end

    p_straps_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        valid |=> (valid && $stable(q)));

    p_single_capture_r4: assert property (@(posedge clk) disable iff (rst)
        capture |-> !valid);
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import sseq_pkg::*;
#(
    parameter int unsigned STRAP_W     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SAMPLE_DLY  = 6250,
    parameter int unsigned SETTLE_DLY  = 45000,
    parameter int unsigned PD_WIN      = 250
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwrgd_n,
    input  logic               pd,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [2:0]         phase,
    output logic [STRAP_W-1:0] straps_q,
    output logic               straps_valid,
    output logic               outputs_en
);
    localparam int unsigned MAX_DLY = max3(SAMPLE_DLY, SETTLE_DLY, PD_WIN);
    localparam int unsigned CW      = cnt_width(MAX_DLY);
    localparam logic [CW-1:0] LD_SAMPLE = CW'(SAMPLE_DLY - 1);
    localparam logic [CW-1:0] LD_SETTLE = CW'(SETTLE_DLY - 1);
    localparam logic [CW-1:0] LD_WIN    = CW'(PD_WIN - 1);

    ctl_s   ctl;
    phase_e state, state_nx;

    logic          dly_load, dly_exp;
    logic [CW-1:0] dly_val;
    logic          win_load, win_exp, win_open, early_pd;
    logic          capture;

    // ---- input synchronization (power-good inverted to active high)
    sseq_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({~pwrgd_n, pd}),
        .q   (ctl)
    );

    // ---- delay timer shared by pre-sample and settle phases
    always_comb begin
        dly_load = 1'b0;
        dly_val  = LD_SAMPLE;
        if (state == PH_WAIT_PG && ctl.pg) begin
            dly_load = 1'b1;
            dly_val  = LD_SAMPLE;
        end else if (state == PH_PRE && dly_exp) begin
            dly_load = 1'b1;
            dly_val  = LD_SETTLE;
        end
    end

    sseq_timer #(.CW(CW)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_exp)
    );

    // ---- early power-down window
    assign win_load = (state == PH_WAIT_PG) && ctl.pg;

    sseq_timer #(.CW(CW)) u_win (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (LD_WIN),
        .expired  (win_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_open <= 1'b0;
            early_pd <= 1'b0;
        end else begin
            if (win_load)                 win_open <= 1'b1;
            else if (win_open && win_exp) win_open <= 1'b0;
            if (win_open && ctl.pd)       early_pd <= 1'b1;
        end
    end

    // ---- phase machine
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_OFF:     state_nx = PH_WAIT_PG;
            PH_WAIT_PG: if (ctl.pg) state_nx = PH_PRE;
            PH_PRE:     if (dly_exp) state_nx = PH_SETTLE;
            PH_SETTLE:  if (dly_exp)
                            state_nx = (early_pd || (win_open && ctl.pd)) ? PH_PWRDN : PH_RUN;
            PH_PWRDN:   if (!ctl.pd) state_nx = PH_RUN;
            PH_RUN:     state_nx = PH_RUN;
            default:    state_nx = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PH_OFF;
        else     state <= state_nx;
    end

    assign capture = (state == PH_PRE) && dly_exp;

    sseq_strap_latch #(.W(STRAP_W)) u_straps (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .d       (strap_in),
        .q       (straps_q),
        .valid   (straps_valid)
    );

    assign phase      = state;
    assign outputs_en = (state == PH_RUN) && !ctl.pd;

    // ---- checks next to the phase logic
    p_wait_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (state == PH_WAIT_PG && !ctl.pg) |=> (state == PH_WAIT_PG));

    p_valid_in_settle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SETTLE) |-> straps_valid);

    p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state == PH_RUN) |=> (state == PH_RUN));

    p_pre_order_r10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_PRE) |=> (state == PH_PRE || state == PH_SETTLE));

    p_settle_order_r10: assert property (@(posedge clk) disable iff (rst)
        (state == PH_SETTLE) |=> (state == PH_SETTLE || state == PH_RUN || state == PH_PWRDN));

    p_pwrdn_order_r7: assert property (@(posedge clk) disable iff (rst)
        (state == PH_PWRDN) |=> (state == PH_PWRDN || state == PH_RUN));
endmodule

// File: tb/startup_seq_tb.sv
module startup_seq_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  SW   = 4;
    localparam int  SYN  = 2;
    localparam int  SDLY = 8;
    localparam int  TDLY = 12;
    localparam int  WIN  = 4;
    localparam int  NV   = 4;

    // stimulus and expected results: strap value, pd edge (0 = none), expect power-down, expect enable
    localparam logic [SW-1:0] V_STRAP [NV] = '{4'hA, 4'h5, 4'hC, 4'h3};
    localparam int            V_PDAT  [NV] = '{0, 1, WIN, WIN + 1};
    localparam bit            V_DN    [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam bit            V_EN    [NV] = '{1'b1, 1'b0, 1'b0, 1'b0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwrgd_n = 1'b1;
    logic          pd = 1'b0;
    logic [SW-1:0] strap_in = '0;
    logic [2:0]    phase;
    logic [SW-1:0] straps_q;
    logic          straps_valid;
    logic          outputs_en;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    startup_seq #(
        .STRAP_W(SW), .SYNC_STAGES(SYN), .SAMPLE_DLY(SDLY),
        .SETTLE_DLY(TDLY), .PD_WIN(WIN)
    ) u_dut (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .pd(pd), .strap_in(strap_in),
        .phase(phase), .straps_q(straps_q), .straps_valid(straps_valid),
        .outputs_en(outputs_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pwrgd_n = 1'b1; pd = 1'b0;
        step(1);
        chk("R1", "phase in reset", phase, 0);
        chk("R1", "straps_q in reset", straps_q, 0);
        chk("R1", "straps_valid in reset", straps_valid, 0);
        chk("R1", "outputs_en in reset", outputs_en, 0);
        rst = 1'b0;
        step(1);
        chk("R1", "phase after reset", phase, 1);
    endtask

    task automatic run_seq(logic [SW-1:0] sv, int pd_at, bit exp_dn, bit exp_en);
        do_reset();
        strap_in = ~sv;
        pwrgd_n  = 1'b0;
        for (int k = 1; k <= 3 + SDLY + TDLY; k++) begin
            step(1);
            if (k == 2) chk("R2", "still waiting", phase, 1);
            if (k == 3) chk("R2", "entered pre-sample", phase, 2);
            if (k == 2 + SDLY) begin
                chk("R3", "not yet captured", straps_valid, 0);
                chk("R10", "pre-sample held", phase, 2);
            end
            if (k == 3 + SDLY) begin
                chk("R3", "settle phase", phase, 3);
                chk("R3", "straps captured", straps_q, sv);
                chk("R3", "straps valid", straps_valid, 1);
                strap_in = ~sv; // R4: later strap changes must not matter
            end
            if (k == 2 + SDLY + TDLY) begin
                chk("R5", "still settling", phase, 3);
                chk("R5", "enable low while settling", outputs_en, 0);
            end
            if (k == 3 + SDLY + TDLY) begin
                chk(exp_dn ? "R6" : "R5", "phase after settle", phase, exp_dn ? 5 : 4);
                chk(exp_dn ? "R6" : "R8", "enable after settle", outputs_en, exp_en);
            end
            if (k == pd_at) pd = 1'b1;
            if (k == 2 + SDLY) strap_in = sv;
            if (k == 5) pwrgd_n = 1'b1; // R9: glitch during pre-sample
            if (k == 7) pwrgd_n = 1'b0;
        end
        chk("R4", "straps held", straps_q, sv);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        for (int v = 0; v < NV; v++) begin
            run_seq(V_STRAP[v], V_PDAT[v], V_DN[v], V_EN[v]);
            if (V_DN[v]) begin
                pd = 1'b0;
                step(2);
                chk("R7", "power-down held until sync", phase, 5);
                step(1);
                chk("R7", "left power-down", phase, 4);
                chk("R7", "enable after power-down", outputs_en, 1);
            end else if (V_PDAT[v] > 0) begin
                pd = 1'b0;
                step(1);
                chk("R8", "enable still gated", outputs_en, 0);
                step(1);
                chk("R8", "enable follows pd", outputs_en, 1);
                chk("R8", "late pd stays in run", phase, 4);
            end else begin
                pwrgd_n = 1'b1;
                step(10);
                chk("R9", "run kept with pwrgd off", phase, 4);
                chk("R9", "enable kept with pwrgd off", outputs_en, 1);
                chk("R9", "straps kept with pwrgd off", straps_q, V_STRAP[v]);
                pwrgd_n = 1'b0;
                step(3);
                chk("R9", "run kept after re-assert", phase, 4);
                pd = 1'b1;
                step(2);
                chk("R8", "pd gates enable in run", outputs_en, 0);
                chk("R8", "pd in run no power-down", phase, 4);
                pd = 1'b0;
                step(2);
                chk("R8", "enable restored", outputs_en, 1);
            end
        end
        // directed: no power-good means waiting forever
        do_reset();
        strap_in = 4'h9;
        step(50);
        chk("R2", "waits without power-good", phase, 1);
        chk("R3", "no capture without power-good", straps_valid, 0);
        chk("R5", "no enable without power-good", outputs_en, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule